// File: doc/BRIEF.md
# Symptom-Driven Fault Diagnosis Controller

This controller works out what caused a failure symptom in a multicore system by replaying execution. A symptom is either a fatal hardware trap (for example a misaligned memory access, or a core that has trapped so often that it has entered its error state) or the output of a hang detector. When a symptom arrives while the controller is idle, it records which core raised it. It then asks the recovery logic to roll back to the last checkpoint and restart on that same core. While the replay runs, it counts retired instructions over a programmable window.

If the window runs out with no new symptom, the fault is classed as transient hardware or non-deterministic software, and execution carries on. If the symptom comes back, the controller asks for a second rollback, this time onto the next core (index plus one, modulo the core count), and watches that replay in the same way. If the second replay is clean, the original core has a permanent defect. If the symptom shows up there as well, the fault is a deterministic software bug. Each verdict is a 2-bit code that is valid for one cycle and comes with the index of the core that raised the first symptom.

The checkpoint store, the rollback datapath, the migration between cores and the symptom detectors all sit outside this block. They are driven through a request/acknowledge pair. The window should be set to about 100K instructions, which is the latency within which most faults show up.

Top module: `fault_diag_ctrl`

## Requirements
- R1: After reset, rb_req_o and verdict_valid_o are low.
- R2: In the idle state, trap_i or hang_i raises rb_req_o on the next cycle, with rb_core_o equal to the sym_core_i sampled with the symptom (an index below N_CORES). The request and its core stay stable until rb_ack_i is seen.
- R3: A symptom that arrives while a rollback request is pending is ignored. Neither rb_core_o nor the phase that follows changes.
- R4: The cycle after rb_ack_i is sampled high with rb_req_o, rb_req_o is low and the replay window starts from zero.
- R5: If a same-core replay sees no symptom before its window of L retire pulses ends (L = win_len_i, L >= 1), verdict_valid_o is high for the cycle after the L-th retire pulse. verdict_o is then 2'b01 (transient or non-deterministic) and suspect_core_o is the original core.
- R6: A symptom during a same-core replay raises rb_req_o on the next cycle, with rb_core_o = (original core + 1) mod N_CORES.
- R7: A different-core replay whose window ends with no symptom gives verdict_o = 2'b10 (permanent defect of the original core), with suspect_core_o = the original core.
- R8: A symptom during a different-core replay gives verdict_o = 2'b11 (deterministic software bug) on the next cycle, with suspect_core_o = the original core.
- R9: If a symptom and the window-ending retire pulse arrive in the same cycle, the symptom wins.
- R10: verdict_valid_o is high for exactly one cycle and never together with rb_req_o. Afterwards the controller is idle, and a new symptom starts a fresh diagnosis.
- R11: Retire pulses that arrive while a rollback is pending do not count toward the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Fatal hardware trap symptom |
| hang_i | input | 1 | Hang detector symptom |
| sym_core_i | input | CW | Core that raised the symptom |
| retire_i | input | 1 | One instruction retired in the replay |
| win_len_i | input | WIN_W | Observation window in retired instructions |
| rb_req_o | output | 1 | Rollback and restart request |
| rb_core_o | output | CW | Core to restart on |
| rb_ack_i | input | 1 | Rollback done acknowledge |
| verdict_valid_o | output | 1 | Verdict strobe, one cycle |
| verdict_o | output | 2 | 01 transient, 10 core defect, 11 software bug |
| suspect_core_o | output | CW | Core that raised the first symptom |

## Verification
The hardest cases to reach are those where two events land on the same edge. One is a symptom that coincides with the window-ending retire pulse. Another is a symptom or a retire pulse that arrives while a rollback is still unacknowledged. The bench builds each of these on purpose, driving inputs on the falling edge. It sweeps every core (three cores, so the alternate core wraps modulo a count that is not a power of two), window lengths 1 to 4, both symptom sources, all three verdict paths, and early as well as coincident second symptoms.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [1:0] {
    VRD_NONE        = 2'b00,
    VRD_TRANSIENT   = 2'b01,
    VRD_CORE_DEFECT = 2'b10,
    VRD_SW_BUG      = 2'b11
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RB1  = 3'd1,
    ST_OBS1 = 3'd2,
    ST_RB2  = 3'd3,
    ST_OBS2 = 3'd4
  } diag_state_e;
endpackage

// File: rtl/diag_window.sv
module diag_window #(
  parameter int unsigned WIN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             retire_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             expired_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W:0]   cnt_inc;

  assign cnt_inc   = {1'b0, cnt_q} + (WIN_W+1)'(1);
  assign expired_o = en_i && retire_i && (cnt_inc >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (en_i && retire_i)  cnt_q <= cnt_inc[WIN_W-1:0];
  end
endmodule

// File: rtl/diag_core_sel.sv
module diag_core_sel #(
  parameter int unsigned N_CORES = 4,
  localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic [CW-1:0] core_i,
  output logic [CW-1:0] alt_o
);
  generate
    if ((1 << CW) == N_CORES) begin : g_pow2
      assign alt_o = core_i + CW'(1);
    end else begin : g_wrap
      assign alt_o = (core_i == CW'(N_CORES-1)) ? '0 : core_i + CW'(1);
    end
  endgenerate
endmodule

// File: rtl/diag_fsm.sv
module diag_fsm
  import diag_pkg::*;
#(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_i,
  input  logic [CW-1:0] sym_core_i,
  input  logic          ack_i,
  input  logic          expired_i,
  output logic          rb_req_o,
  output logic          alt_o,
  output logic          start_o,
  output logic          observe_o,
  output logic [CW-1:0] core_o,
  output logic          vld_o,
  output verdict_e      verdict_o
);
  diag_state_e state_q, state_d;
  logic [CW-1:0] core_q;
  logic          load;
  logic          vld_d, vld_q;
  verdict_e      vrd_d, vrd_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    vld_d   = 1'b0;
    vrd_d   = VRD_NONE;
    unique case (state_q)
      ST_IDLE: if (sym_i) begin state_d = ST_RB1; load = 1'b1; end
      ST_RB1:  if (ack_i) state_d = ST_OBS1;
      ST_OBS1: begin
        // symptom has priority over window expiry
        if (sym_i) state_d = ST_RB2;
        else if (expired_i) begin
          state_d = ST_IDLE; vld_d = 1'b1; vrd_d = VRD_TRANSIENT;
        end
      end
      ST_RB2:  if (ack_i) state_d = ST_OBS2;
      ST_OBS2: begin
        if (sym_i) begin
          state_d = ST_IDLE; vld_d = 1'b1; vrd_d = VRD_SW_BUG;
        end else if (expired_i) begin
          state_d = ST_IDLE; vld_d = 1'b1; vrd_d = VRD_CORE_DEFECT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      vld_q   <= 1'b0;
      vrd_q   <= VRD_NONE;
    end else begin
      state_q <= state_d;
      if (load) core_q <= sym_core_i;
      vld_q   <= vld_d;
      vrd_q   <= vrd_d;
    end
  end

  assign rb_req_o  = (state_q == ST_RB1) || (state_q == ST_RB2);
  assign alt_o     = (state_q == ST_RB2);
  assign start_o   = rb_req_o && ack_i;
  assign observe_o = (state_q == ST_OBS1) || (state_q == ST_OBS2);
  assign core_o    = core_q;
  assign vld_o     = vld_q;
  assign verdict_o = vrd_q;
endmodule

// File: rtl/fault_diag_ctrl.sv
module fault_diag_ctrl
  import diag_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned WIN_W   = 20,
  localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic             hang_i,
  input  logic [CW-1:0]    sym_core_i,
  input  logic             retire_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             rb_req_o,
  output logic [CW-1:0]    rb_core_o,
  input  logic             rb_ack_i,
  output logic             verdict_valid_o,
  output logic [1:0]       verdict_o,
  output logic [CW-1:0]    suspect_core_o
);
  logic          sym, alt, start, observe, expired;
  logic [CW-1:0] core_q, core_alt;
  verdict_e      vrd;

  assign sym = trap_i | hang_i;

  diag_fsm #(.CW(CW)) i_fsm (
    .clk_i, .rst_ni,
    .sym_i(sym), .sym_core_i, .ack_i(rb_ack_i), .expired_i(expired),
    .rb_req_o, .alt_o(alt), .start_o(start), .observe_o(observe),
    .core_o(core_q), .vld_o(verdict_valid_o), .verdict_o(vrd)
  );

  diag_window #(.WIN_W(WIN_W)) i_window (
    .clk_i, .rst_ni,
    .start_i(start), .en_i(observe), .retire_i, .len_i(win_len_i),
    .expired_o(expired)
  );

  diag_core_sel #(.N_CORES(N_CORES)) i_core_sel (
    .core_i(core_q), .alt_o(core_alt)
  );

  assign rb_core_o      = alt ? core_alt : core_q;
  assign verdict_o      = vrd;
  assign suspect_core_o = core_q;
endmodule

// File: rtl/diag_checker.sv
module diag_checker #(
  parameter int unsigned N_CORES = 4,
  localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rb_req_o,
  input logic          rb_ack_i,
  input logic [CW-1:0] rb_core_o,
  input logic          verdict_valid_o,
  input logic [1:0]    verdict_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_req_o && !rb_ack_i |=> rb_req_o && $stable(rb_core_o)); // R2
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_req_o && rb_ack_i |=> !rb_req_o); // R4
  AST_CORE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_req_o |-> int'(rb_core_o) < int'(N_CORES)); // R6
  AST_VRD_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> verdict_o != 2'b00); // R5
  AST_VRD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |=> !verdict_valid_o); // R10
  AST_VRD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> !rb_req_o); // R10
endmodule

bind fault_diag_ctrl diag_checker #(.N_CORES(N_CORES)) i_diag_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rb_req_o(rb_req_o), .rb_ack_i(rb_ack_i),
  .rb_core_o(rb_core_o), .verdict_valid_o(verdict_valid_o), .verdict_o(verdict_o)
);

// File: tb/test_fault_diag_ctrl.sv
`timescale 1ns/1ps
module test_fault_diag_ctrl;
  localparam int NC = 3;
  localparam int WW = 4;
  localparam int CW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic trap_i = 0, hang_i = 0, retire_i = 0, rb_ack_i = 0;
  logic [CW-1:0] sym_core_i = '0;
  logic [WW-1:0] win_len_i = '0;
  logic rb_req_o, verdict_valid_o;
  logic [CW-1:0] rb_core_o, suspect_core_o;
  logic [1:0] verdict_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  fault_diag_ctrl #(.N_CORES(NC), .WIN_W(WW)) i_fault_diag_ctrl (.*);

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sym_on(input bit use_hang, input int core);
    sym_core_i = CW'(core);
    if (use_hang) hang_i = 1; else trap_i = 1;
  endtask

  task automatic sym_off(); trap_i = 0; hang_i = 0; endtask

  // expects request pending for core; pokes ignored events, then acks
  task automatic do_rollback(input int core);
    chk("R2 req", rb_req_o, 1);
    chk("R2 core", rb_core_o, core);
    trap_i = 1; sym_core_i = CW'((core + 2) % NC); retire_i = 1; // R3, R11
    tick();
    sym_off(); retire_i = 0;
    chk("R3 req held", rb_req_o, 1);
    chk("R3 core unchanged", rb_core_o, core);
    rb_ack_i = 1;
    tick();
    rb_ack_i = 0;
    chk("R4 req dropped", rb_req_o, 0);
  endtask

  // L-1 clean retires then a final event
  task automatic window_pre(input int len);
    for (int i = 1; i < len; i++) begin
      retire_i = 1;
      tick();
      retire_i = 0;
      chk("R11 no early verdict", verdict_valid_o, 0);
      chk("R4 no early req", rb_req_o, 0);
    end
  endtask

  task automatic expect_verdict(input string req, input int code, input int core);
    chk(req, verdict_valid_o, 1);
    chk(req, verdict_o, code);
    chk(req, suspect_core_o, core);
    tick();
    chk("R10 one cycle", verdict_valid_o, 0);
    chk("R10 idle", rb_req_o, 0);
  endtask

  // scen: 0 transient, 1 core defect, 2 sw bug; late: symptom on final retire
  task automatic run(input int core, input int len, input int scen,
                     input bit use_hang, input bit late);
    win_len_i = WW'(len);
    sym_on(use_hang, core);
    tick();
    sym_off();
    do_rollback(core);
    if (scen == 0) begin
      window_pre(len);
      retire_i = 1; tick(); retire_i = 0;
      expect_verdict("R5 transient", 1, core);
      return;
    end
    if (late) window_pre(len);
    retire_i = late; sym_on(use_hang, (core + 1) % NC);
    tick();
    retire_i = 0; sym_off();
    chk(late ? "R9 symptom wins" : "R6 no verdict", verdict_valid_o, 0);
    do_rollback((core + 1) % NC); // R6 alternate core
    if (scen == 1) begin
      window_pre(len);
      retire_i = 1; tick(); retire_i = 0;
      expect_verdict("R7 core defect", 2, core);
    end else begin
      if (late) window_pre(len);
      retire_i = late; sym_on(!use_hang, core);
      tick();
      retire_i = 0; sym_off();
      expect_verdict(late ? "R9 R8 sw bug" : "R8 sw bug", 3, core);
    end
  endtask

  initial begin
    #1;
    chk("R1 req", rb_req_o, 0);
    chk("R1 verdict", verdict_valid_o, 0);
    tick(); tick();
    rst_ni = 1;
    tick();
    chk("R1 req after reset", rb_req_o, 0);
    chk("R1 verdict after reset", verdict_valid_o, 0);
    for (int c = 0; c < NC; c++)
      for (int l = 1; l <= 4; l++)
        for (int s = 0; s < 3; s++)
          for (int h = 0; h < 2; h++)
            for (int lt = 0; lt < 2; lt++)
              run(c, l, s, h[0], lt[0]);
    // R10: symptom in the verdict cycle starts a fresh diagnosis
    win_len_i = 1;
    sym_on(0, 2); tick(); sym_off();
    do_rollback(2);
    retire_i = 1; tick(); retire_i = 0;
    chk("R10 verdict", verdict_valid_o, 1);
    sym_on(1, 1); tick(); sym_off();
    chk("R10 fresh req", rb_req_o, 1);
    chk("R10 fresh core", rb_core_o, 1);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule